// File: doc/BRIEF.md
# Depth Cache Line Compressor

This block shrinks one depth cache line before it goes to memory and restores it on the way back. A line is eight 32-bit words. Each word carries a 24-bit depth value in its upper bits and an 8-bit stencil value in its low byte. The packer sorts each line into one of four kinds:

- a cleared line, in which every word equals a programmable clear value;
- a line whose words all lie close to the first word;
- a line whose words lie moderately close to the first word;
- anything else, which is stored raw.

It emits a left-aligned payload together with its length in bits. In the same cycle it reports the largest depth value in the line, which the depth hierarchy uses when it updates.

The unpacker takes a 2-bit kind code and a payload and rebuilds the eight words exactly. Each direction is a single register stage with its own valid strobe, so one line can enter each side every cycle.

Top module: `depth_line_codec`

## Requirements
- R1: When every word of the packed line equals `clear_word`, the packer reports kind 2'b00, length 0 and an all-zero payload. This holds even when a denser mode would also fit.
- R2: When the line is not cleared and every difference (word i minus word 0, i = 1..7) lies in [-8,7], the packer reports kind 2'b10 and length 60. Payload bits 31:0 hold word 0. Bits 32+4(i-1) upward hold the low 4 bits of difference i. All payload bits from 60 up are zero.
- R3: When the line is neither cleared nor covered by R2, and every difference lies in [-32768,32767], the kind is 2'b11 and the length is 144. Bits 31:0 hold word 0, and bits 32+16(i-1) upward hold the low 16 bits of difference i. Bits from 144 up are zero.
- R4: Every other line gets kind 2'b01 and length 256, with the payload equal to the line, word i at bits 32i+31:32i.
- R5: Differences are taken modulo 2^32 over the whole word, stencil byte included. A step from 32'h7FFF_FFFF to 32'h8000_0000 therefore counts as +1.
- R6: The reported maximum is the largest of the eight 24-bit depth fields, bits 31:8 of each word, compared as unsigned values. The stencil byte, bits 7:0, never affects it.
- R7: Packer outputs change one clock after a cycle with `pk_valid` high, and `pk_out_valid` is high exactly in that following cycle.
- R8: The unpacker registers its result one clock after `up_valid`, with `up_out_valid` high exactly then. For every kind, feeding back a packed kind and payload returns the original 256-bit line bit for bit.
- R9: Unpacking kind 2'b00 yields eight copies of `clear_word` whatever the payload holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_word | input | 32 | Value that marks a cleared word |
| pk_valid | input | 1 | A line to pack is present |
| pk_line | input | 256 | Line to pack, word i at bits 32i+31:32i |
| pk_out_valid | output | 1 | Packed result is valid |
| pk_kind | output | 2 | Kind code of the packed line |
| pk_payload | output | 256 | Left-aligned packed payload |
| pk_len | output | 9 | Payload length in bits |
| pk_max_depth | output | 24 | Largest depth field of the line |
| up_valid | input | 1 | A payload to unpack is present |
| up_kind | input | 2 | Kind code of the payload |
| up_payload | input | 256 | Payload to unpack |
| up_out_valid | output | 1 | Rebuilt line is valid |
| up_line | output | 256 | Rebuilt line |

## Verification
The cases hardest to reach from the ports are the exact edges between modes. A difference of -8 or +7 must stay in 4-bit mode, 8 must fall to 16-bit mode, and -32768 against +32768 splits 16-bit from raw. Among these the wrap across the sign of the full 32-bit word is the most easily missed, and random words almost never land there. The stimulus therefore builds lines from a random reference plus chosen offsets at those edges, and adds a wrapping reference. It also mixes in lines equal to `clear_word` that would fit 4-bit mode, to show that the cleared kind takes precedence. Random lines of each class are then sent through pack and unpack to check the round trip.

// File: rtl/depth_line_codec.sv
module depth_line_codec #(
  parameter int WORDS    = 8,
  parameter int WORD_W   = 32,
  parameter int STEN_W   = 8,
  parameter int NARROW_W = 4,
  parameter int WIDE_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WORD_W-1:0]             clear_word,
  input  logic                          pk_valid,
  input  logic [WORDS*WORD_W-1:0]       pk_line,
  output logic                          pk_out_valid,
  output logic [1:0]                    pk_kind,
  output logic [WORDS*WORD_W-1:0]       pk_payload,
  output logic [$clog2(WORDS*WORD_W+1)-1:0] pk_len,
  output logic [WORD_W-STEN_W-1:0]      pk_max_depth,
  input  logic                          up_valid,
  input  logic [1:0]                    up_kind,
  input  logic [WORDS*WORD_W-1:0]       up_payload,
  output logic                          up_out_valid,
  output logic [WORDS*WORD_W-1:0]       up_line
);
  localparam int LINE_W     = WORDS * WORD_W;
  localparam int DEPTH_W    = WORD_W - STEN_W;
  localparam int LEN_W      = $clog2(LINE_W + 1);
  localparam int NARROW_LEN = WORD_W + (WORDS - 1) * NARROW_W;
  localparam int WIDE_LEN   = WORD_W + (WORDS - 1) * WIDE_W;
  localparam logic [1:0] K_CLEAR  = 2'b00;
  localparam logic [1:0] K_RAW    = 2'b01;
  localparam logic [1:0] K_NARROW = 2'b10;
  localparam logic [1:0] K_WIDE   = 2'b11;

  logic [WORD_W-1:0] ref_w;
  logic [WORDS-1:0]  same_clr;
  logic [WORDS-1:1]  fit_n, fit_w;
  logic [WORD_W-1:0] diff [1:WORDS-1];
  logic [LINE_W-1:0] narrow_pl, wide_pl;
  logic [DEPTH_W-1:0] max_c;
  logic [1:0]        kind_c;

  assign ref_w = pk_line[WORD_W-1:0];
  assign narrow_pl[WORD_W-1:0] = ref_w;
  assign wide_pl[WORD_W-1:0]   = ref_w;
  assign narrow_pl[LINE_W-1:NARROW_LEN] = '0;
  assign wide_pl[LINE_W-1:WIDE_LEN]     = '0;

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_clr
      assign same_clr[g] = (pk_line[g*WORD_W +: WORD_W] == clear_word);
    end
    for (g = 1; g < WORDS; g++) begin : g_diff
      assign diff[g]  = pk_line[g*WORD_W +: WORD_W] - ref_w;
      assign fit_n[g] = (&diff[g][WORD_W-1:NARROW_W-1]) | ~(|diff[g][WORD_W-1:NARROW_W-1]);
      assign fit_w[g] = (&diff[g][WORD_W-1:WIDE_W-1])   | ~(|diff[g][WORD_W-1:WIDE_W-1]);
      assign narrow_pl[WORD_W + (g-1)*NARROW_W +: NARROW_W] = diff[g][NARROW_W-1:0];
      assign wide_pl[WORD_W + (g-1)*WIDE_W +: WIDE_W]       = diff[g][WIDE_W-1:0];
    end
  endgenerate

  assign kind_c = (&same_clr) ? K_CLEAR  :
                  (&fit_n)    ? K_NARROW :
                  (&fit_w)    ? K_WIDE   : K_RAW;

  always_comb begin
    max_c = pk_line[STEN_W +: DEPTH_W];
    for (int i = 1; i < WORDS; i++)
      if (pk_line[i*WORD_W+STEN_W +: DEPTH_W] > max_c)
        max_c = pk_line[i*WORD_W+STEN_W +: DEPTH_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_out_valid <= 1'b0;
      pk_kind      <= K_CLEAR;
      pk_payload   <= '0;
      pk_len       <= '0;
      pk_max_depth <= '0;
    end else begin
      pk_out_valid <= pk_valid;
      if (pk_valid) begin
        pk_kind      <= kind_c;
        pk_max_depth <= max_c;
        case (kind_c)
          K_CLEAR:  begin pk_payload <= '0;        pk_len <= '0; end
          K_NARROW: begin pk_payload <= narrow_pl; pk_len <= LEN_W'(NARROW_LEN); end
          K_WIDE:   begin pk_payload <= wide_pl;   pk_len <= LEN_W'(WIDE_LEN); end
          default:  begin pk_payload <= pk_line;   pk_len <= LEN_W'(LINE_W); end
        endcase
      end
    end
  end

  logic [LINE_W-1:0] line_c;
  always_comb begin
    logic [WORD_W-1:0] base;
    base   = up_payload[WORD_W-1:0];
    line_c = up_payload;
    case (up_kind)
      K_CLEAR:  line_c = {WORDS{clear_word}};
      K_NARROW: for (int i = 1; i < WORDS; i++)
                  line_c[i*WORD_W +: WORD_W] = base + {{(WORD_W-NARROW_W){up_payload[WORD_W+(i-1)*NARROW_W+NARROW_W-1]}},
                                                       up_payload[WORD_W+(i-1)*NARROW_W +: NARROW_W]};
      K_WIDE:   for (int i = 1; i < WORDS; i++)
                  line_c[i*WORD_W +: WORD_W] = base + {{(WORD_W-WIDE_W){up_payload[WORD_W+(i-1)*WIDE_W+WIDE_W-1]}},
                                                       up_payload[WORD_W+(i-1)*WIDE_W +: WIDE_W]};
      default:  line_c = up_payload;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_out_valid <= 1'b0;
      up_line      <= '0;
    end else begin
      up_out_valid <= up_valid;
      if (up_valid) up_line <= line_c;
    end
  end

  // R7
  pk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid |=> pk_out_valid);
  // R7
  pk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pk_valid |=> !pk_out_valid);
  // R8
  up_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> up_out_valid);
  // R1
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_out_valid && pk_kind == K_CLEAR) |-> (pk_len == '0 && pk_payload == '0));
  // R2
  narrow_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_out_valid && pk_kind == K_NARROW) |-> (pk_payload[LINE_W-1:NARROW_LEN] == '0));
  // R9
  unpack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_kind == K_CLEAR) |=> (up_line == {WORDS{$past(clear_word)}}));
  generate
    for (g = 0; g < WORDS; g++) begin : g_maxchk
      // R6
      max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |=> (pk_max_depth >= $past(pk_line[g*WORD_W+STEN_W +: DEPTH_W])));
    end
  endgenerate
endmodule

// File: tb/depth_line_codec_test.sv
module depth_line_codec_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  clear_word = 32'hFFFF_FF00;
  logic         pk_valid = 1'b0;
  logic [255:0] pk_line = '0;
  logic         pk_out_valid;
  logic [1:0]   pk_kind;
  logic [255:0] pk_payload;
  logic [8:0]   pk_len;
  logic [23:0]  pk_max_depth;
  logic         up_valid = 1'b0;
  logic [1:0]   up_kind = 2'b00;
  logic [255:0] up_payload = '0;
  logic         up_out_valid;
  logic [255:0] up_line;

  int n_chk = 0;
  int n_bad = 0;

  depth_line_codec uut (
    .clk(clk), .rst_n(rst_n), .clear_word(clear_word),
    .pk_valid(pk_valid), .pk_line(pk_line), .pk_out_valid(pk_out_valid),
    .pk_kind(pk_kind), .pk_payload(pk_payload), .pk_len(pk_len),
    .pk_max_depth(pk_max_depth), .up_valid(up_valid), .up_kind(up_kind),
    .up_payload(up_payload), .up_out_valid(up_out_valid), .up_line(up_line)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] m_kind(input logic [255:0] ln, input logic [31:0] cw);
    bit all_clr = 1'b1, n_ok = 1'b1, w_ok = 1'b1;
    for (int i = 0; i < 8; i++) if (ln[i*32 +: 32] != cw) all_clr = 1'b0;
    for (int i = 1; i < 8; i++) begin
      int d;
      d = int'(ln[i*32 +: 32] - ln[31:0]);
      if (d < -8 || d > 7) n_ok = 1'b0;
      if (d < -32768 || d > 32767) w_ok = 1'b0;
    end
    if (all_clr) return 2'b00;
    if (n_ok) return 2'b10;
    if (w_ok) return 2'b11;
    return 2'b01;
  endfunction

  function automatic logic [255:0] m_payload(input logic [255:0] ln, input logic [1:0] k);
    logic [255:0] p = '0;
    logic [31:0] d;
    if (k == 2'b01) return ln;
    if (k == 2'b00) return '0;
    p[31:0] = ln[31:0];
    for (int i = 1; i < 8; i++) begin
      d = ln[i*32 +: 32] - ln[31:0];
      if (k == 2'b10) p[32 + 4*(i-1) +: 4] = d[3:0];
      else            p[32 + 16*(i-1) +: 16] = d[15:0];
    end
    return p;
  endfunction

  function automatic logic [8:0] m_len(input logic [1:0] k);
    case (k)
      2'b00: return 9'd0;
      2'b10: return 9'd60;
      2'b11: return 9'd144;
      default: return 9'd256;
    endcase
  endfunction

  function automatic logic [23:0] m_max(input logic [255:0] ln);
    logic [23:0] m = 24'd0;
    for (int i = 0; i < 8; i++) if (ln[i*32+8 +: 24] > m) m = ln[i*32+8 +: 24];
    return m;
  endfunction

  task automatic round_trip(input logic [255:0] ln, input string tag);
    logic [1:0] ek;
    ek = m_kind(ln, clear_word);
    @(negedge clk);
    pk_valid = 1'b1; pk_line = ln;
    @(negedge clk);
    pk_valid = 1'b0;
    check(pk_out_valid == 1'b1, {tag, " R7 valid"}, 256'(pk_out_valid), 256'(1));
    check(pk_kind == ek, {tag, " R1 R2 R3 R4 kind"}, 256'(pk_kind), 256'(ek));
    check(pk_len == m_len(ek), {tag, " R2 R3 R4 len"}, 256'(pk_len), 256'(m_len(ek)));
    check(pk_payload == m_payload(ln, ek), {tag, " R2 R3 R4 payload"}, pk_payload, m_payload(ln, ek));
    check(pk_max_depth == m_max(ln), {tag, " R6 max"}, 256'(pk_max_depth), 256'(m_max(ln)));
    up_valid = 1'b1; up_kind = pk_kind; up_payload = pk_payload;
    @(negedge clk);
    up_valid = 1'b0;
    check(up_out_valid == 1'b1, {tag, " R8 valid"}, 256'(up_out_valid), 256'(1));
    check(up_line == ln, {tag, " R8 round trip"}, up_line, ln);
  endtask

  function automatic logic [255:0] near_line(input logic [31:0] base, input int lo, input int hi);
    logic [255:0] l;
    l[31:0] = base;
    for (int i = 1; i < 8; i++) l[i*32 +: 32] = base + 32'($urandom_range(hi - lo) + lo);
    return l;
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [255:0] l;
    void'($urandom(32'd20240611));
    #1;
    check(pk_out_valid == 1'b0 && up_out_valid == 1'b0, "R7 R8 reset valids",
          256'({pk_out_valid, up_out_valid}), 256'(0));
    check(pk_len == 9'd0 && up_line == '0, "R7 reset data", 256'(pk_len), 256'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pk_out_valid == 1'b0, "R7 idle no valid", 256'(pk_out_valid), 256'(0));

    round_trip({8{clear_word}}, "R1 cleared line");
    clear_word = 32'h0000_0000;
    round_trip('0, "R1 cleared with new clear value");
    l = '0; l[7*32 +: 32] = 32'd1;
    round_trip(l, "R2 near-clear line");
    round_trip({8{32'h1234_5678}}, "R2 constant line");
    l = {32'h1000_0007, 32'h0FFF_FFF8, {5{32'h1000_0000}}, 32'h1000_0000};
    round_trip(l, "R2 edges -8 and +7");
    l[7*32 +: 32] = 32'h1000_0008;
    round_trip(l, "R3 delta +8");
    l = {32'h4000_8000, 32'h3FFF_8000, {6{32'h4000_0000}}};
    l[7*32 +: 32] = 32'h4000_7FFF;
    round_trip(l, "R3 edges -32768 and +32767");
    l[7*32 +: 32] = 32'h4000_8000;
    round_trip(l, "R4 delta +32768");
    l = {{7{32'h8000_0000}}, 32'h7FFF_FFFF};
    round_trip(l, "R5 wrap across sign");
    l = {32'h0000_0003, {6{32'h0000_0000}}, 32'hFFFF_FFFE};
    round_trip(l, "R5 wrap across zero");
    l = {32'h00AB_CD01, 32'h00AB_CDFF, {6{32'h0000_0000}}};
    round_trip(l, "R6 stencil ignored");
    check(pk_max_depth == 24'h00AB_CD, "R6 stencil byte not compared",
          256'(pk_max_depth), 256'(24'h00AB_CD));
    l = {{7{32'h0000_00FF}}, 32'hFFFF_FF00};
    round_trip(l, "R6 top depth only in word 0");

    @(negedge clk);
    up_valid = 1'b1; up_kind = 2'b00; up_payload = {8{32'hDEAD_BEEF}};
    @(negedge clk);
    up_valid = 1'b0;
    check(up_line == {8{clear_word}}, "R9 payload ignored for cleared", up_line, {8{clear_word}});
    @(negedge clk);
    check(pk_out_valid == 1'b0 && up_out_valid == 1'b0, "R7 R8 single-cycle valids",
          256'({pk_out_valid, up_out_valid}), 256'(0));

    clear_word = 32'h3F80_0000;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] b;
      b = $urandom;
      case (n % 5)
        0: for (int i = 0; i < 8; i++) l[i*32 +: 32] = $urandom;
        1: l = near_line(b, -8, 7);
        2: l = near_line(b, -32768, 32767);
        3: l = near_line(b, -40000, 40000);
        default: begin
          l = {8{clear_word}};
          if ($urandom_range(1) == 1) l[$urandom_range(7)*32 +: 32] = clear_word + 32'd1;
        end
      endcase
      round_trip(l, "R8 random mix");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule